// File: doc/BRIEF.md
# Locked Translation Entry Access Port

This block lets software save and restore the locked entries of a small address translation buffer one word at a time. A request carries an opcode and a 32-bit data word. Two select opcodes load two separate index registers: one names the entry that reads come from, the other names the entry that writes go to. Three staging words carry an entry in pieces: a virtual word (page number and address space identifier), an attribute word (domain and execute-never) and a physical word (page number, page size, permission code and a locked/valid bit).

The physical word is always the last step. Writing it commits the staged virtual word, the staged attribute word and the new physical word into the write-selected entry in one cycle. Selecting a read entry copies that entry into the staging words, so the three read opcodes return a consistent image. A read of the physical word completes that sequence. Page-number bits that the page size leaves untranslated are forced to zero when an entry is stored.

A combinational lookup port searches the locked entries for a virtual address and identifier. It returns the translated address, the entry's domain and a fault flag that combines the permission code with the access type.

Top module: `lkd_tlb_port`

## Requirements
- R1: After reset every entry is invalid, all staging words and both index registers are zero, `rsp_valid` is 0, `req_ready` is 1 and `lk_hit` is 0.
- R2: Opcode 0 loads the read index and opcode 1 loads the write index, each from `req_wdata[IDXW-1:0]`. Each index is kept apart from the other, so a read index never redirects a commit and a write index never redirects a read.
- R3: Opcode 3 writes the virtual staging word and opcode 7 writes the attribute staging word, and neither changes the array. Opcode 5 commits the virtual staging word, the attribute staging word and its own data word as one entry at the write index.
- R4: Opcode 0 copies the selected entry into the staging words. Opcodes 2, 4 and 6 return the virtual, physical and attribute staging words as one response. Virtual word layout: [31:12] page number, [7:0] identifier. Physical word layout: [31:12] page number, [5:4] size, [3:1] permission, [0] locked/valid. Attribute word layout: [10:7] domain, [0] execute-never. All other bits read as zero.
- R5: The size field selects the page: 00 is 16 MB, 01 is 4 KB, 10 is 64 KB, 11 is 1 MB. Stored virtual and physical page-number bits below the page size are zero. A lookup hit forms its address from the stored physical page and the untranslated bits of the lookup address.
- R6: Only entries with the locked/valid bit set can hit.
- R7: Permission codes for a (user, write) access: 000 and 100 always fault; 001 faults user accesses; 010 faults user writes; 011 never faults; 101 faults user accesses and any write; 110 and 111 fault writes. A miss never faults.
- R8: An instruction fetch (`lk_fetch`=1) that hits an entry with execute-never set faults. `lk_domain` gives the hit entry's domain.
- R9: A lookup hits only when `lk_asid` equals the entry's identifier.
- R10: With an index at or above DEPTH, a commit leaves the array unchanged and a read selection loads all-zero staging words.
- R11: A response stays valid with stable data until `rsp_ready` is 1. While a response is valid and `rsp_ready` is 0, `req_ready` is 0.
- R12: When several entries hit, the lowest index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_op | input | 3 | Opcode 0..7 (see R2 to R4) |
| req_wdata | input | 32 | Select index or staging data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Consumer accepts the response |
| rsp_data | output | 32 | Read response word |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Lookup address space identifier |
| lk_user | input | 1 | Access is from user mode |
| lk_write | input | 1 | Access is a write |
| lk_fetch | input | 1 | Access is an instruction fetch |
| lk_hit | output | 1 | A locked entry matches |
| lk_pa | output | 32 | Translated address, zero on a miss |
| lk_domain | output | 4 | Domain of the hit entry |
| lk_fault | output | 1 | Access is denied |

## Verification
The request port follows valid/ready rules: a request moves on a clock edge where `req_valid` and `req_ready` are both high. A read response then waits, and blocks further requests, until `rsp_ready` is high. The hardest case to reach from the ports is a lookup that hits two entries at once, and checking it against the commit ordering. The stimulus first commits an entry at a higher index and leaves it in place. It then reprograms index 0 several times through the full staging sequence for the permission sweep. Last, it rewrites index 0 with the same page and identifier, so that both entries match and only the priority decides which physical page comes back. Holding `rsp_ready` low after a read brings out the back-pressure case.

// File: rtl/lkd_pkg.sv
package lkd_pkg;

  typedef enum logic [2:0] {
    OP_SEL_RD = 3'd0,
    OP_SEL_WR = 3'd1,
    OP_RD_VA  = 3'd2,
    OP_WR_VA  = 3'd3,
    OP_RD_PA  = 3'd4,
    OP_WR_PA  = 3'd5,
    OP_RD_AT  = 3'd6,
    OP_WR_AT  = 3'd7
  } lkd_op_e;

  typedef struct packed {
    logic [31:0] vpn;   // page number in [31:12], low bits zero
    logic [7:0]  asid;
    logic [31:0] ppn;
    logic [1:0]  size;
    logic [2:0]  ap;
    logic        lv;
    logic [3:0]  dom;
    logic        xn;
  } lkd_entry_t;

  localparam logic [31:0] PAGE_MASK = 32'hFFFF_F000;
  localparam logic [31:0] VA_KEEP   = 32'hFFFF_F0FF;
  localparam logic [31:0] AT_KEEP   = 32'h0000_0781;

  // page-number bits left untranslated by a page size
  function automatic logic [31:0] untrans_mask(input logic [1:0] sz);
    case (sz)
      2'b00:   return 32'h00FF_F000;
      2'b01:   return 32'h0000_0000;
      2'b10:   return 32'h0000_F000;
      default: return 32'h000F_F000;
    endcase
  endfunction

  function automatic logic [31:0] pack_va(input lkd_entry_t e);
    return {e.vpn[31:12], 4'b0, e.asid};
  endfunction

  function automatic logic [31:0] pack_pa(input lkd_entry_t e);
    return {e.ppn[31:12], 6'b0, e.size, e.ap, e.lv};
  endfunction

  function automatic logic [31:0] pack_at(input lkd_entry_t e);
    return {21'b0, e.dom, 6'b0, e.xn};
  endfunction

endpackage

// File: rtl/lkd_entry_store.sv
module lkd_entry_store
  import lkd_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int IDXW  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDXW-1:0]         wr_idx,
  input  lkd_entry_t              wr_entry,
  input  logic [IDXW-1:0]         rd_idx,
  output lkd_entry_t              rd_entry,
  output lkd_entry_t [DEPTH-1:0]  entries_o
);

  lkd_entry_t [DEPTH-1:0] entries_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        entries_q[i] <= '0;
      else if (wr_en && (wr_idx == IDXW'(i)))
        entries_q[i] <= wr_entry;
    end

    // stored page numbers never carry untranslated bits
    p_stored_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((entries_q[i].vpn | entries_q[i].ppn) & untrans_mask(entries_q[i].size)) == 32'h0);
  end

  // out-of-range index reads as an all-zero entry
  always_comb begin
    rd_entry = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rd_idx == IDXW'(i)) rd_entry = entries_q[i];
  end

  assign entries_o = entries_q;

  p_oob_commit_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ({1'b0, wr_idx} >= (IDXW+1)'(DEPTH))) |=> $stable(entries_q));

endmodule

// File: rtl/lkd_lookup.sv
module lkd_lookup
  import lkd_pkg::*;
#(
  parameter int DEPTH = 6
) (
  input  lkd_entry_t [DEPTH-1:0] entries,
  input  logic [31:0]            va,
  input  logic [7:0]             asid,
  output logic                   hit,
  output lkd_entry_t             hit_entry,
  output logic [31:0]            pa
);

  logic [31:0] pn_mask;

  // scan downward so the lowest matching index is the last assignment
  always_comb begin
    hit       = 1'b0;
    hit_entry = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (entries[i].lv && (entries[i].asid == asid) &&
          ((va & PAGE_MASK & ~untrans_mask(entries[i].size)) == entries[i].vpn)) begin
        hit       = 1'b1;
        hit_entry = entries[i];
      end
    end
  end

  assign pn_mask = PAGE_MASK & ~untrans_mask(hit_entry.size);
  assign pa      = hit ? (hit_entry.ppn | (va & ~pn_mask)) : 32'h0;

endmodule

// File: rtl/lkd_perm_check.sv
module lkd_perm_check
  import lkd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  lkd_entry_t ent,
  input  logic       user,
  input  logic       write,
  input  logic       fetch,
  output logic       fault
);

  logic ap_fault;

  always_comb begin
    case (ent.ap)
      3'b001:  ap_fault = user;
      3'b010:  ap_fault = user && write;
      3'b011:  ap_fault = 1'b0;
      3'b101:  ap_fault = user || write;
      3'b110,
      3'b111:  ap_fault = write;
      default: ap_fault = 1'b1;   // 000 and reserved 100
    endcase
  end

  assign fault = hit && (ap_fault || (fetch && ent.xn));

  p_miss_no_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> !fault);

  p_xn_fetch_faults_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && fetch && ent.xn) |-> fault);

endmodule

// File: rtl/lkd_tlb_port.sv
module lkd_tlb_port
  import lkd_pkg::*;
#(
  parameter int DEPTH = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [2:0]  req_op,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_data,
  input  logic [31:0] lk_va,
  input  logic [7:0]  lk_asid,
  input  logic        lk_user,
  input  logic        lk_write,
  input  logic        lk_fetch,
  output logic        lk_hit,
  output logic [31:0] lk_pa,
  output logic [3:0]  lk_domain,
  output logic        lk_fault
);

  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  lkd_op_e           op;
  logic              acc, is_read;
  logic [IDXW-1:0]   rd_idx_q, wr_idx_q, store_rd_idx;
  logic [31:0]       va_stg, pa_stg, at_stg;
  logic [31:0]       new_mask;
  lkd_entry_t        new_entry, sel_entry, hit_entry;
  lkd_entry_t [DEPTH-1:0] entries;

  assign op        = lkd_op_e'(req_op);
  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign is_read   = (op == OP_RD_VA) || (op == OP_RD_PA) || (op == OP_RD_AT);

  // entry assembled on a physical-word write, untranslated bits cleared
  assign new_mask = ~untrans_mask(req_wdata[5:4]);
  always_comb begin
    new_entry      = '0;
    new_entry.vpn  = {va_stg[31:12], 12'b0} & new_mask;
    new_entry.asid = va_stg[7:0];
    new_entry.ppn  = {req_wdata[31:12], 12'b0} & new_mask;
    new_entry.size = req_wdata[5:4];
    new_entry.ap   = req_wdata[3:1];
    new_entry.lv   = req_wdata[0];
    new_entry.dom  = at_stg[10:7];
    new_entry.xn   = at_stg[0];
  end

  assign store_rd_idx = (acc && op == OP_SEL_RD) ? req_wdata[IDXW-1:0] : rd_idx_q;

  lkd_entry_store #(.DEPTH(DEPTH), .IDXW(IDXW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (acc && op == OP_WR_PA),
    .wr_idx    (wr_idx_q),
    .wr_entry  (new_entry),
    .rd_idx    (store_rd_idx),
    .rd_entry  (sel_entry),
    .entries_o (entries)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_idx_q <= '0;
      wr_idx_q <= '0;
      va_stg   <= '0;
      pa_stg   <= '0;
      at_stg   <= '0;
    end else if (acc) begin
      case (op)
        OP_SEL_RD: begin
          rd_idx_q <= req_wdata[IDXW-1:0];
          va_stg   <= pack_va(sel_entry);
          pa_stg   <= pack_pa(sel_entry);
          at_stg   <= pack_at(sel_entry);
        end
        OP_SEL_WR: wr_idx_q <= req_wdata[IDXW-1:0];
        OP_WR_VA:  va_stg   <= req_wdata & VA_KEEP;
        OP_WR_AT:  at_stg   <= req_wdata & AT_KEEP;
        OP_WR_PA:  pa_stg   <= pack_pa(new_entry);
        default: ;
      endcase
    end
  end

  // read response stream
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (acc && is_read) begin
      rsp_valid <= 1'b1;
      rsp_data  <= (op == OP_RD_VA) ? va_stg : (op == OP_RD_PA) ? pa_stg : at_stg;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  p_rsp_from_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready && req_op inside {3'd2, 3'd4, 3'd6}));

  lkd_lookup #(.DEPTH(DEPTH)) u_lookup (
    .entries   (entries),
    .va        (lk_va),
    .asid      (lk_asid),
    .hit       (lk_hit),
    .hit_entry (hit_entry),
    .pa        (lk_pa)
  );

  assign lk_domain = lk_hit ? hit_entry.dom : 4'h0;

  lkd_perm_check u_perm (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (lk_hit),
    .ent   (hit_entry),
    .user  (lk_user),
    .write (lk_write),
    .fetch (lk_fetch),
    .fault (lk_fault)
  );

endmodule

// File: tb/lkd_tlb_port_tb_top.sv
module lkd_tlb_port_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, rsp_ready = 1'b1;
  logic [2:0]  req_op = '0;
  logic [31:0] req_wdata = '0, lk_va = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_user = 1'b0, lk_write = 1'b0, lk_fetch = 1'b0;
  logic        req_ready, rsp_valid, lk_hit, lk_fault;
  logic [31:0] rsp_data, lk_pa;
  logic [3:0]  lk_domain;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz

  lkd_tlb_port #(.DEPTH(6)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .lk_va(lk_va), .lk_asid(lk_asid),
    .lk_user(lk_user), .lk_write(lk_write), .lk_fetch(lk_fetch), .lk_hit(lk_hit),
    .lk_pa(lk_pa), .lk_domain(lk_domain), .lk_fault(lk_fault));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [2:0] op, output logic [31:0] d);
    send(op, d);
    @(negedge clk);
    d = rsp_valid ? rsp_data : 32'hDEAD_BEEF;
  endtask

  task automatic put(input int idx, input logic [31:0] va, input logic [31:0] at,
                     input logic [31:0] pa);
    send(3'd1, idx);
    send(3'd3, va);
    send(3'd7, at);
    send(3'd5, pa);
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] id, input logic u,
                      input logic w, input logic f);
    @(negedge clk);
    lk_va = va; lk_asid = id; lk_user = u; lk_write = w; lk_fetch = f;
    #1;
  endtask

  function automatic logic exp_fault(input logic [2:0] ap, input logic u, input logic w);
    case (ap)
      3'd1: return u;
      3'd2: return u & w;
      3'd3: return 1'b0;
      3'd5: return u | w;
      3'd6, 3'd7: return w;
      default: return 1'b1;
    endcase
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 req_ready", req_ready, 1);
    chk("R1 rsp_valid", rsp_valid, 0);
    look(32'h0, 8'h0, 0, 0, 0);
    chk("R1 lk_hit", lk_hit, 0);
    rd(3'd2, d); chk("R1 va staging", d, 0);
  endtask

  task automatic t_commit();
    logic [31:0] d;
    send(3'd1, 2);
    send(3'd3, 32'h1234_5005);
    send(3'd7, 32'h0000_0180);
    look(32'h1234_5678, 8'h05, 1, 1, 0);
    chk("R3 no commit before physical write", lk_hit, 0);
    send(3'd5, 32'hABCD_E017);
    look(32'h1234_5678, 8'h05, 1, 1, 0);
    chk("R3 hit after commit", lk_hit, 1);
    chk("R5 4KB address", lk_pa, 32'hABCD_E678);
    chk("R8 domain", lk_domain, 3);
    chk("R7 ap011 no fault", lk_fault, 0);
    look(32'h1234_5678, 8'h06, 0, 0, 0);
    chk("R9 identifier mismatch", lk_hit, 0);
    send(3'd0, 0);
    rd(3'd4, d); chk("R2 read index apart from write index", d, 0);
    send(3'd0, 2);
    rd(3'd2, d); chk("R4 va readback", d, 32'h1234_5005);
    rd(3'd6, d); chk("R4 attr readback", d, 32'h0000_0180);
    rd(3'd4, d); chk("R4 pa readback", d, 32'hABCD_E017);
  endtask

  task automatic t_sizes();
    logic [31:0] d;
    put(3, 32'h1234_5007, 0, 32'hABCD_E037);
    put(4, 32'h1234_5008, 0, 32'hABCD_E007);
    put(5, 32'h1234_5009, 0, 32'hABCD_E027);
    send(3'd0, 3);
    rd(3'd2, d); chk("R5 1MB va", d, 32'h1230_0007);
    rd(3'd4, d); chk("R5 1MB pa", d, 32'hABC0_0037);
    send(3'd0, 4);
    rd(3'd2, d); chk("R5 16MB va", d, 32'h1200_0008);
    rd(3'd4, d); chk("R5 16MB pa", d, 32'hAB00_0007);
    send(3'd0, 5);
    rd(3'd2, d); chk("R5 64KB va", d, 32'h1234_0009);
    rd(3'd4, d); chk("R5 64KB pa", d, 32'hABCD_0027);
    look(32'h123F_FFFF, 8'h07, 0, 0, 0); chk("R5 1MB lookup", lk_pa, 32'hABCF_FFFF);
    look(32'h12FE_DCBA, 8'h08, 0, 0, 0); chk("R5 16MB lookup", lk_pa, 32'hABFE_DCBA);
    look(32'h1234_F00D, 8'h09, 0, 0, 0); chk("R5 64KB lookup", lk_pa, 32'hABCD_F00D);
  endtask

  task automatic t_lv();
    logic [31:0] d;
    put(1, 32'h5000_000A, 0, 32'h6000_0016);
    look(32'h5000_0123, 8'h0A, 0, 0, 0);
    chk("R6 unlocked entry no hit", lk_hit, 0);
    send(3'd0, 1);
    rd(3'd4, d); chk("R6 unlocked entry stored", d, 32'h6000_0016);
  endtask

  task automatic t_perm();
    for (int ap = 0; ap < 8; ap++) begin
      put(0, 32'h7000_000B, 32'h0000_0281, 32'h8000_0011 | (ap << 1));
      for (int k = 0; k < 4; k++) begin
        look(32'h7000_0444, 8'h0B, k[1], k[0], 0);
        chk($sformatf("R7 ap=%0d u=%0d w=%0d", ap, k[1], k[0]), lk_fault,
            exp_fault(ap[2:0], k[1], k[0]));
      end
    end
    look(32'h7000_0444, 8'h0B, 0, 0, 1);
    chk("R8 xn fetch fault", lk_fault, 1);
    chk("R8 domain 5", lk_domain, 5);
    look(32'h7000_0444, 8'h0B, 0, 0, 0);
    chk("R8 xn data read ok", lk_fault, 0);
    look(32'h7100_0000, 8'h0B, 1, 1, 1);
    chk("R7 miss no fault", lk_fault, 0);
  endtask

  task automatic t_prio();
    put(0, 32'h1234_5005, 0, 32'h1111_1017);
    look(32'h1234_5678, 8'h05, 0, 0, 0);
    chk("R12 lowest index wins", lk_pa, 32'h1111_1678);
  endtask

  task automatic t_oob();
    logic [31:0] d;
    put(7, 32'h9999_9001, 0, 32'h9999_9017);
    look(32'h9999_9000, 8'h01, 0, 0, 0);
    chk("R10 oob commit ignored", lk_hit, 0);
    send(3'd0, 7);
    rd(3'd2, d); chk("R10 oob read va zero", d, 0);
    rd(3'd4, d); chk("R10 oob read pa zero", d, 0);
  endtask

  task automatic t_backpressure();
    send(3'd0, 2);
    rsp_ready = 1'b0;
    send(3'd4, 0);
    @(negedge clk);
    chk("R11 rsp valid", rsp_valid, 1);
    chk("R11 req blocked", req_ready, 0);
    repeat (3) @(negedge clk);
    chk("R11 rsp held", rsp_valid, 1);
    chk("R11 data stable", rsp_data, 32'hABCD_E017);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R11 rsp released", rsp_valid, 0);
    chk("R11 req ready again", req_ready, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_commit();
    t_sizes();
    t_lv();
    t_perm();
    t_prio();
    t_oob();
    t_backpressure();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule